// File: doc/BRIEF.md
# SPI Master with Automatic Slave Select

This block moves one byte at a time over a four-wire serial link as the link master. Software writes a byte into a single transmit holding register. The engine copies it into its shift logic at the next idle cycle and clocks it out while it collects a byte from the slave. At the end of the frame it leaves the received byte in a single receive holding register. The serial clock comes from a programmable divider. Static configuration inputs choose the idle level of the clock, the sampling phase and the bit order.

When both the fault detector and the select-drive control are on, the block generates the active-low slave select itself. The select covers the whole frame, from the start of the first bit to half a clock period after the eighth bit. When the fault detector is on and the select drive is off, the select pin acts as an input. A low level on that pin means another master has taken the link, which raises a sticky fault flag and stops the engine. Three flags (transmit holding empty, receive holding full and fault) stay readable at all times. Two enables merge them into one interrupt line.

Top module: `spi_master_auto`

## Requirements
- R1: While `rst_n` is low, `tx_empty` is 1, `rx_full`, `mode_fault` and `irq` are 0, `ss_n` is 1 and `sclk` equals `cpol`.
- R2: Every frame is exactly 8 bits. The byte written through `tx_wdata` appears on `mosi`, and the 8 bits taken from `miso` are delivered on `rx_rdata`. With `lsb_first`=1 bit 0 travels first, and with 0 bit 7 travels first.
- R3: The idle level of `sclk` is `cpol`. Each half period of `sclk` lasts `half_div`+1 system clocks, so the first `sclk` edge comes `half_div`+1 clocks after the select falls.
- R4: With `cpha`=0, a bit is valid from the start of its bit time and `miso` is sampled on the first `sclk` edge of the bit; `mosi` changes on the second edge. With `cpha`=1, `mosi` changes on the first edge and `miso` is sampled on the second edge.
- R5: `ss_n` goes low only while `fault_det_en` and `ss_auto_en` are both 1. Otherwise it stays high for the whole frame.
- R6: In automatic mode, `ss_n` falls in the same cycle the byte leaves the transmit holding register. It rises `half_div`+1 clocks after the last `sclk` edge of the eighth bit.
- R7: A `tx_wr` strobe clears `tx_empty` on the next clock. `tx_empty` sets again one clock later, when an idle engine takes the byte.
- R8: `rx_full` sets, and `rx_rdata` updates, in the cycle `ss_n` rises at the end of the frame. An `rx_rd` strobe clears `rx_full`.
- R9: With `fault_det_en`=1 and `ss_auto_en`=0, a low `ss_in_n` sets `mode_fault` on the next clock. The same clock stops a running frame (no `rx_full`, `sclk` back at idle). While the flag is set, no new frame starts. `flt_ack` clears the flag only once `ss_in_n` is high again.
- R10: `irq` = (`rx_irq_en` and (`rx_full` or `mode_fault`)) or (`tx_irq_en` and `tx_empty`). With both enables at 0, `irq` stays 0 while the flags remain readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive holding register; clears `rx_full` |
| rx_rdata | output | 8 | Last byte received |
| flt_ack | input | 1 | Clear strobe for `mode_fault` |
| cpol | input | 1 | Idle level of `sclk` |
| cpha | input | 1 | Sampling phase select |
| lsb_first | input | 1 | 1: least significant bit first |
| half_div | input | DIV_W | Half period of `sclk` minus one, in system clocks |
| fault_det_en | input | 1 | Enables fault detection on `ss_in_n` |
| ss_auto_en | input | 1 | With `fault_det_en`, drives `ss_n` automatically |
| rx_irq_en | input | 1 | Routes `rx_full` and `mode_fault` to `irq` |
| tx_irq_en | input | 1 | Routes `tx_empty` to `irq` |
| miso | input | 1 | Serial data from the slave |
| ss_in_n | input | 1 | Sensed select level, used for fault detection |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Automatic active-low slave select |
| tx_empty | output | 1 | Transmit holding register is free |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| mode_fault | output | 1 | Sticky fault flag |
| irq | output | 1 | Merged interrupt request |

## Verification
A strobe driven before edge E is seen one clock after E in `tx_empty` or `rx_full`, and the start of a frame (`ss_n` low, `tx_empty` back to 1) follows one clock after that. The first `sclk` edge is due `half_div`+1 clocks after the select falls. The select rises `half_div`+1 clocks after the final `sclk` edge, in the same cycle that `rx_full` sets. The bench drives inputs on falling edges and counts falling edges between events, so each count matches these registered latencies exactly. The slave model changes `miso` only half a serial period away from the edge where the engine samples it. The interrupt output is combinational from flags and enables, so it is checked 1 ns after an enable changes.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int unsigned FRAME_BITS = 8;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned HALF_LAST  = 2 * FRAME_BITS;       // trailing half after last bit
  localparam int unsigned HALF_W     = $clog2(HALF_LAST + 1);

  typedef logic [FRAME_BITS-1:0] frame_t;
  typedef logic [HALF_W-1:0]     half_t;
  typedef logic [IDX_W-1:0]      idx_t;

  // position in the byte of the k-th serial bit
  function automatic idx_t wire_pos(input logic lsb_first, input idx_t k);
    return lsb_first ? k : (idx_t'(FRAME_BITS - 1) - k);
  endfunction
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  always_comb begin
    at_end = (cnt_q == half_div);
    if (!run || at_end) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
    tick = run && at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
  import spi_master_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t load_data,
  input  logic   lsb_first,
  input  logic   cpha,
  input  logic   drive_en,
  input  idx_t   drive_k,
  input  logic   sample_en,
  input  idx_t   sample_k,
  input  logic   miso,
  output logic   mosi,
  output frame_t rx_byte
);
  frame_t tx_q, tx_d, rx_q, rx_d;
  logic   mosi_q, mosi_d;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    mosi_d = mosi_q;
    if (load) begin
      tx_d = load_data;
      if (!cpha) mosi_d = load_data[wire_pos(lsb_first, '0)];
    end
    if (drive_en)  mosi_d = tx_q[wire_pos(lsb_first, drive_k)];
    if (sample_en) rx_d[wire_pos(lsb_first, sample_k)] = miso;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
    end else begin
      if (load)      tx_q   <= tx_d;
      if (sample_en) rx_q   <= rx_d;
      mosi_q <= mosi_d;
    end
  end

  assign mosi    = mosi_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_master_auto.sv
module spi_master_auto
  import spi_master_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_wr,
  input  logic [7:0]       tx_wdata,
  input  logic             rx_rd,
  output logic [7:0]       rx_rdata,
  input  logic             flt_ack,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic [DIV_W-1:0] half_div,
  input  logic             fault_det_en,
  input  logic             ss_auto_en,
  input  logic             rx_irq_en,
  input  logic             tx_irq_en,
  input  logic             miso,
  input  logic             ss_in_n,
  output logic             sclk,
  output logic             mosi,
  output logic             ss_n,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             mode_fault,
  output logic             irq
);
  logic   run_q, run_d, txe_q, txe_d, rxf_q, rxf_d, flt_q, flt_d;
  half_t  h_q, h_d, nh;
  frame_t txbuf_q, txbuf_d, rxbuf_q, rxbuf_d, rx_byte;
  logic   tick, mid, odd_ent, even_ent, end_ev, flt_cond, start;
  logic   drive_en, sample_en;
  idx_t   drive_k, sample_k;

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run_q), .half_div(half_div), .tick(tick)
  );

  // half-period sequencing: halves 0..HALF_LAST, sclk active in odd halves
  always_comb begin
    nh        = h_q + 1'b1;
    end_ev    = tick && (h_q == half_t'(HALF_LAST));
    mid       = tick && (h_q != half_t'(HALF_LAST));
    odd_ent   = mid && nh[0];
    even_ent  = mid && !nh[0];
    drive_en  = cpha ? odd_ent : (even_ent && (nh != half_t'(HALF_LAST)));
    drive_k   = cpha ? h_q[IDX_W:1] : nh[IDX_W:1];
    sample_en = cpha ? even_ent : odd_ent;
    sample_k  = h_q[IDX_W:1];
    flt_cond  = fault_det_en && !ss_auto_en && !ss_in_n;
    start     = !run_q && !txe_q && !flt_q && !flt_cond;
  end

  spi_shift_unit u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_data(txbuf_q),
    .lsb_first(lsb_first), .cpha(cpha),
    .drive_en(drive_en), .drive_k(drive_k),
    .sample_en(sample_en), .sample_k(sample_k),
    .miso(miso), .mosi(mosi), .rx_byte(rx_byte)
  );

  // next state
  always_comb begin
    run_d   = run_q;
    h_d     = h_q;
    txe_d   = txe_q;
    txbuf_d = txbuf_q;
    rxf_d   = rxf_q;
    rxbuf_d = rxbuf_q;
    flt_d   = flt_q;

    if (flt_cond)    run_d = 1'b0;
    else if (start)  begin run_d = 1'b1; h_d = '0; end
    else if (end_ev) run_d = 1'b0;
    else if (tick)   h_d = nh;

    if (start) txe_d = 1'b1;
    if (tx_wr) begin txe_d = 1'b0; txbuf_d = tx_wdata; end

    if (rx_rd) rxf_d = 1'b0;
    if (end_ev && !flt_cond) begin rxf_d = 1'b1; rxbuf_d = rx_byte; end

    if (flt_ack)  flt_d = 1'b0;
    if (flt_cond) flt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      h_q     <= '0;
      txe_q   <= 1'b1;
      txbuf_q <= '0;
      rxf_q   <= 1'b0;
      rxbuf_q <= '0;
      flt_q   <= 1'b0;
    end else begin
      run_q <= run_d;
      h_q   <= h_d;
      txe_q <= txe_d;
      if (tx_wr) txbuf_q <= txbuf_d;
      rxf_q <= rxf_d;
      if (end_ev) rxbuf_q <= rxbuf_d;
      flt_q <= flt_d;
    end
  end

  assign sclk       = cpol ^ (run_q && h_q[0]);
  assign ss_n       = !(fault_det_en && ss_auto_en && run_q);
  assign tx_empty   = txe_q;
  assign rx_full    = rxf_q;
  assign rx_rdata   = rxbuf_q;
  assign mode_fault = flt_q;
  assign irq        = (rx_irq_en && (rxf_q || flt_q)) || (tx_irq_en && txe_q);
endmodule

// File: rtl/spi_master_auto_chk.sv
module spi_master_auto_chk (
  input logic clk,
  input logic rst_n,
  input logic cpol,
  input logic fault_det_en,
  input logic ss_auto_en,
  input logic rx_irq_en,
  input logic tx_irq_en,
  input logic tx_wr,
  input logic sclk,
  input logic ss_n,
  input logic tx_empty,
  input logic rx_full,
  input logic mode_fault,
  input logic irq
);
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_det_en && ss_auto_en && ss_n) |-> (sclk == cpol));

  p_ss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_det_en && ss_auto_en) |-> ss_n);

  p_txe_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_empty);

  p_rxf_at_ss_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_det_en && ss_auto_en && $past(fault_det_en && ss_auto_en) && $rose(rx_full))
      |-> $rose(ss_n));

  p_fault_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |-> (sclk == cpol));

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_irq_en && !tx_irq_en) |-> !irq);

  p_irq_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq_en && tx_empty) |-> irq);
endmodule

bind spi_master_auto spi_master_auto_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpol(cpol), .fault_det_en(fault_det_en),
  .ss_auto_en(ss_auto_en), .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
  .tx_wr(tx_wr), .sclk(sclk), .ss_n(ss_n), .tx_empty(tx_empty),
  .rx_full(rx_full), .mode_fault(mode_fault), .irq(irq)
);

// File: tb/spi_master_auto_test.sv
module spi_master_auto_test;
  logic       clk = 1'b0;
  logic       rst_n, tx_wr, rx_rd, flt_ack, cpol, cpha, lsb_first;
  logic [7:0] tx_wdata, rx_rdata, half_div;
  logic       fault_det_en, ss_auto_en, rx_irq_en, tx_irq_en, miso, ss_in_n;
  logic       sclk, mosi, ss_n, tx_empty, rx_full, mode_fault, irq;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  spi_master_auto #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .flt_ack(flt_ack),
    .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .half_div(half_div),
    .fault_det_en(fault_det_en), .ss_auto_en(ss_auto_en),
    .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en), .miso(miso),
    .ss_in_n(ss_in_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
    .tx_empty(tx_empty), .rx_full(rx_full), .mode_fault(mode_fault), .irq(irq)
  );

  // {cpol, cpha, lsb_first, 5'b0, half_div, tx byte, slave byte}
  localparam logic [31:0] VEC [6] = '{
    {3'b000, 5'd0, 8'd1, 8'hA5, 8'h3C},
    {3'b100, 5'd0, 8'd0, 8'h81, 8'h7E},
    {3'b010, 5'd0, 8'd2, 8'h5A, 8'hC3},
    {3'b111, 5'd0, 8'd1, 8'h01, 8'h80},
    {3'b001, 5'd0, 8'd3, 8'hF0, 8'h96},
    {3'b110, 5'd0, 8'd0, 8'hFF, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] v);
    logic [7:0] got, pat;
    int         n, hd;
    pat = v[7:0];
    hd  = int'(v[23:16]);
    got = '0;
    @(negedge clk);
    cpol = v[31]; cpha = v[30]; lsb_first = v[29]; half_div = v[23:16];
    miso = v[29] ? pat[0] : pat[7];
    tx_wr = 1'b1; tx_wdata = v[15:8];
    @(negedge clk);
    tx_wr = 1'b0;
    chk("R7 tx_empty clears after write", tx_empty, 0);
    @(negedge clk);
    chk("R7 tx_empty sets on load", tx_empty, 1);
    chk("R6 ss_n low at first bit", ss_n, 0);
    chk("R3 sclk idle at frame start", sclk, cpol);
    n = 0;
    while (sclk == cpol) begin @(negedge clk); n++; end
    chk("R3 half period before first edge", n, hd + 1);
    for (int k = 0; k < 8; k++) begin
      got[lsb_first ? k : 7 - k] = mosi;
      if (cpha) miso = lsb_first ? pat[k] : pat[7 - k];
      while (sclk != cpol) @(negedge clk);
      if (!cpha && k < 7) miso = lsb_first ? pat[k + 1] : pat[6 - k];
      if (k < 7) while (sclk == cpol) @(negedge clk);
    end
    n = 0;
    while (!ss_n) begin @(negedge clk); n++; end
    chk("R6 ss_n rises half period after last edge", n, hd + 1);
    chk("R2 R4 mosi byte in mode", got, v[15:8]);
    chk("R8 rx_full at frame end", rx_full, 1);
    chk("R2 R4 rx byte in mode", rx_rdata, pat);
    chk("R10 irq off when polling", irq, 0);
    rx_irq_en = 1'b1; #1;
    chk("R10 irq from rx_full", irq, 1);
    rx_irq_en = 1'b0;
    @(negedge clk);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    chk("R8 rx_full cleared by read", rx_full, 0);
  endtask

  task automatic wait_rx();
    int n = 0;
    while (!rx_full && n < 500) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic seen_low;
    rst_n = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; flt_ack = 1'b0; tx_wdata = '0;
    cpol = 1'b0; cpha = 1'b0; lsb_first = 1'b0; half_div = 8'd1;
    fault_det_en = 1'b1; ss_auto_en = 1'b1; rx_irq_en = 1'b0; tx_irq_en = 1'b0;
    miso = 1'b0; ss_in_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tx_empty in reset", tx_empty, 1);
    chk("R1 rx_full in reset", rx_full, 0);
    chk("R1 mode_fault in reset", mode_fault, 0);
    chk("R1 ss_n in reset", ss_n, 1);
    chk("R1 sclk in reset", sclk, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    tx_irq_en = 1'b1; #1;
    chk("R10 irq from tx_empty", irq, 1);
    tx_irq_en = 1'b0; #1;
    chk("R10 irq masked", irq, 0);

    for (int i = 0; i < 6; i++) xfer(VEC[i]);

    // select output disabled: ss_n must stay high
    @(negedge clk);
    fault_det_en = 1'b0; ss_auto_en = 1'b0; cpol = 1'b0; cpha = 1'b0;
    half_div = 8'd0; miso = 1'b1;
    tx_wr = 1'b1; tx_wdata = 8'h3C;
    @(negedge clk);
    tx_wr = 1'b0;
    seen_low = 1'b0;
    for (int n = 0; n < 60 && !rx_full; n++) begin
      if (!ss_n) seen_low = 1'b1;
      @(negedge clk);
    end
    chk("R5 ss_n stays high without auto select", seen_low, 0);
    chk("R2 rx byte with miso held high", rx_rdata, 8'hFF);
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;

    // mode fault while idle
    fault_det_en = 1'b1; ss_auto_en = 1'b0; ss_in_n = 1'b0;
    @(negedge clk);
    chk("R9 fault set by low select input", mode_fault, 1);
    rx_irq_en = 1'b1; #1;
    chk("R10 irq from mode fault", irq, 1);
    rx_irq_en = 1'b0;
    tx_wr = 1'b1; tx_wdata = 8'h55;
    @(negedge clk);
    tx_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 no start while fault", tx_empty, 0);
    chk("R9 sclk idle while fault", sclk, cpol);
    flt_ack = 1'b1; @(negedge clk); flt_ack = 1'b0;
    chk("R9 ack ignored while input low", mode_fault, 1);
    ss_in_n = 1'b1; flt_ack = 1'b1;
    @(negedge clk);
    flt_ack = 1'b0;
    chk("R9 ack clears fault", mode_fault, 0);
    @(negedge clk);
    chk("R7 queued byte loads after ack", tx_empty, 1);
    wait_rx();
    chk("R8 frame completes after ack", rx_full, 1);
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;

    // mode fault during a frame
    half_div = 8'd2;
    tx_wr = 1'b1; tx_wdata = 8'hC9;
    @(negedge clk);
    tx_wr = 1'b0;
    repeat (5) @(negedge clk);
    ss_in_n = 1'b0;
    @(negedge clk);
    chk("R9 fault during frame", mode_fault, 1);
    chk("R9 sclk idle after abort", sclk, cpol);
    repeat (60) @(negedge clk);
    chk("R9 aborted frame sets no rx_full", rx_full, 0);
    ss_in_n = 1'b1; flt_ack = 1'b1;
    @(negedge clk);
    flt_ack = 1'b0;
    chk("R9 fault cleared", mode_fault, 0);
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule